// File: doc/BRIEF.md
# Dual-Channel Buffered PWM Timer

The block holds two up-counters, each paired with four compare registers. Each counter runs from zero up to the value in its period register, A. It then strobes a match output and wraps to zero. A channel's PWM output is high from the start of each period until the counter reaches the duty register, B. The channel can either stop itself when the period match occurs or keep running until software clears its run flag.

Registers C and D of each channel can be used as plain storage, or as staging registers for A and B. When they act as staging registers, new period and duty values are copied in only at a period boundary, so a waveform never contains a torn period. A sync bit couples the two channels: when either counter wraps, the other counter restarts at the same time.

Software reaches everything through one flat register port. It writes whole words, and reads back through a combinational data path.

Top module: `dual_pwm_timer`

## Requirements
- R1: The control register at address 0 holds a run flag per channel: bit 0 for channel 0 and bit 1 for channel 1. Writing 1 starts that channel's counter and writing 0 stops it. A stopped channel's PWM output is low.
- R2: Bit 2 (channel 0) and bit 3 (channel 1) of the control register select free-running. When this bit is 0, the period match clears the channel's run flag in hardware, and the flag reads back as 0.
- R3: When the free-running bit is 1, the channel keeps counting after every period match, and its run flag stays 1.
- R4: Channel 0's registers A, B, C and D sit at addresses 2, 3, 4 and 5. Channel 1's sit at addresses 6 to 9. While a channel runs, `match_o` is high in the cycle in which its counter equals A. The counter is 0 in the next cycle, so the period is A+1 cycles.
- R5: During a period, a running channel's PWM output is high for min(B, A+1) cycles, starting from counter value 0. It goes low when the counter equals B.
- R6: The mode register is at address 1, and bit 0 is the sync bit. With sync at 1, a period match on either channel resets the other channel's counter to 0 in the next cycle. With sync at 0, the channels run independently.
- R7: Mode bits 1 and 2 make C and D of channel 0 the staging registers for A and B. Bits 3 and 4 do the same for channel 1. A staged value is copied only at that channel's period match. A register used as general storage is never copied.
- R8: Mode bits 7 to 5 are unassigned. They always read as 1, and writes to them have no effect.
- R9: The control register is written as a whole word. If a write lands in the same cycle as a hardware clear, the written run bit decides the flag's value: 1 keeps the channel running and 0 stops it.
- R10: After reset, the control register reads 0, the mode register reads 0xE0, and both PWM and match outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | CNT_W | Register write data |
| reg_rdata_o | output | CNT_W | Register read data (combinational) |
| pwm_o | output | 2 | PWM output per channel |
| match_o | output | 2 | Period match strobe per channel |

## Verification
The bench goes after the boundaries of the duty cycle: B of zero, B equal to A, and B larger than A. A comparison with an off-by-one error would give one high cycle too many or too few, or would drop the B-above-A case that should stay high. It places a control write in exactly the cycle of a self-stop match. A design that let the hardware clear win over a written 1 would leave the channel stopped. It checks that a staged value is not copied before the period boundary, and that general-purpose C is never copied. It also runs with sync on and off, so a missing cross-reset shows up as an extra match on the longer channel.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int NUM_CH   = 2;
    localparam int ADR_CTRL = 0;
    localparam int ADR_MODE = 1;
    localparam int ADR_CH0  = 2;
    localparam int CH_SPAN  = 4;

    typedef enum logic [1:0] {
        SEL_A = 2'd0,
        SEL_B = 2'd1,
        SEL_C = 2'd2,
        SEL_D = 2'd3
    } cmp_sel_e;
endpackage

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             peer_rst_i,
    input  logic             stage_a_i,
    input  logic             stage_b_i,
    input  logic             wr_en_i,
    input  cmp_sel_e         wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cmp_a_o,
    output logic [CNT_W-1:0] cmp_b_o,
    output logic [CNT_W-1:0] cmp_c_o,
    output logic [CNT_W-1:0] cmp_d_o,
    output logic             match_o,
    output logic             pwm_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] a;
        logic [CNT_W-1:0] b;
        logic [CNT_W-1:0] c;
        logic [CNT_W-1:0] d;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     hit;

    always_comb begin
        st_d = st_q;
        hit  = run_i && (st_q.cnt == st_q.a);
        if (wr_en_i) begin
            case (wr_sel_i)
                SEL_A:   st_d.a = wr_data_i;
                SEL_B:   st_d.b = wr_data_i;
                SEL_C:   st_d.c = wr_data_i;
                default: st_d.d = wr_data_i;
            endcase
        end
        if (hit) begin
            st_d.cnt = '0;
            if (stage_a_i) st_d.a = st_q.c;
            if (stage_b_i) st_d.b = st_q.d;
        end else if (peer_rst_i) begin
            st_d.cnt = '0;
        end else if (run_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign match_o = hit;
    assign pwm_o   = run_i && (st_q.cnt < st_q.b);
    assign cnt_o   = st_q.cnt;
    assign cmp_a_o = st_q.a;
    assign cmp_b_o = st_q.b;
    assign cmp_c_o = st_q.c;
    assign cmp_d_o = st_q.d;
endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
    import pwm_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ctrl_we_i,
    input  logic              mode_we_i,
    input  logic [7:0]        wdata_i,
    input  logic [NUM_CH-1:0] match_i,
    output logic [NUM_CH-1:0] run_o,
    output logic [NUM_CH-1:0] free_o,
    output logic              sync_o,
    output logic [NUM_CH-1:0] stage_a_o,
    output logic [NUM_CH-1:0] stage_b_o,
    output logic [7:0]        ctrl_rd_o,
    output logic [7:0]        mode_rd_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] run;
        logic [NUM_CH-1:0] free;
        logic              sync;
        logic [NUM_CH-1:0] stage_a;
        logic [NUM_CH-1:0] stage_b;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (match_i[i] && !st_q.free[i]) st_d.run[i] = 1'b0;
        end
        if (ctrl_we_i) begin
            st_d.run  = wdata_i[1:0];
            st_d.free = wdata_i[3:2];
        end
        if (mode_we_i) begin
            st_d.sync       = wdata_i[0];
            st_d.stage_a[0] = wdata_i[1];
            st_d.stage_b[0] = wdata_i[2];
            st_d.stage_a[1] = wdata_i[3];
            st_d.stage_b[1] = wdata_i[4];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign run_o     = st_q.run;
    assign free_o    = st_q.free;
    assign sync_o    = st_q.sync;
    assign stage_a_o = st_q.stage_a;
    assign stage_b_o = st_q.stage_b;
    assign ctrl_rd_o = {4'b0000, st_q.free, st_q.run};
    assign mode_rd_o = {3'b111, st_q.stage_b[1], st_q.stage_a[1],
                        st_q.stage_b[0], st_q.stage_a[0], st_q.sync};
endmodule

// File: rtl/dual_pwm_timer.sv
module dual_pwm_timer
    import pwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [CNT_W-1:0]  reg_wdata_i,
    output logic [CNT_W-1:0]  reg_rdata_o,
    output logic [1:0]        pwm_o,
    output logic [1:0]        match_o
);
    localparam int PAD_W = CNT_W - 8;

    logic [NUM_CH-1:0]            run_w, free_w, stage_a_w, stage_b_w, peer_rst_w;
    logic                         sync_w;
    logic [7:0]                   ctrl_rd_w, mode_rd_w;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_w, a_w, b_w, c_w, d_w;
    logic                         ctrl_we, mode_we;

    assign ctrl_we = reg_we_i && (reg_addr_i == ADDR_W'(ADR_CTRL));
    assign mode_we = reg_we_i && (reg_addr_i == ADDR_W'(ADR_MODE));

    pwm_ctrl u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ctrl_we_i (ctrl_we),
        .mode_we_i (mode_we),
        .wdata_i   (reg_wdata_i[7:0]),
        .match_i   (match_o),
        .run_o     (run_w),
        .free_o    (free_w),
        .sync_o    (sync_w),
        .stage_a_o (stage_a_w),
        .stage_b_o (stage_b_w),
        .ctrl_rd_o (ctrl_rd_w),
        .mode_rd_o (mode_rd_w)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int BASE = ADR_CH0 + CH_SPAN * i;
        logic     hit;
        cmp_sel_e sel;

        assign hit = reg_we_i && (reg_addr_i >= ADDR_W'(BASE))
                              && (reg_addr_i <= ADDR_W'(BASE + CH_SPAN - 1));
        assign sel = cmp_sel_e'(reg_addr_i[1:0] - 2'(BASE));
        assign peer_rst_w[i] = sync_w && match_o[NUM_CH - 1 - i];

        pwm_chan #(.CNT_W(CNT_W)) u_chan (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .run_i      (run_w[i]),
            .peer_rst_i (peer_rst_w[i]),
            .stage_a_i  (stage_a_w[i]),
            .stage_b_i  (stage_b_w[i]),
            .wr_en_i    (hit),
            .wr_sel_i   (sel),
            .wr_data_i  (reg_wdata_i),
            .cnt_o      (cnt_w[i]),
            .cmp_a_o    (a_w[i]),
            .cmp_b_o    (b_w[i]),
            .cmp_c_o    (c_w[i]),
            .cmp_d_o    (d_w[i]),
            .match_o    (match_o[i]),
            .pwm_o      (pwm_o[i])
        );
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_W'(ADR_CTRL)) reg_rdata_o = {{PAD_W{1'b0}}, ctrl_rd_w};
        if (reg_addr_i == ADDR_W'(ADR_MODE)) reg_rdata_o = {{PAD_W{1'b0}}, mode_rd_w};
        for (int i = 0; i < NUM_CH; i++) begin
            if (reg_addr_i == ADDR_W'(ADR_CH0 + CH_SPAN * i))     reg_rdata_o = a_w[i];
            if (reg_addr_i == ADDR_W'(ADR_CH0 + CH_SPAN * i + 1)) reg_rdata_o = b_w[i];
            if (reg_addr_i == ADDR_W'(ADR_CH0 + CH_SPAN * i + 2)) reg_rdata_o = c_w[i];
            if (reg_addr_i == ADDR_W'(ADR_CH0 + CH_SPAN * i + 3)) reg_rdata_o = d_w[i];
        end
    end
endmodule

// File: rtl/dual_pwm_timer_chk.sv
module dual_pwm_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 ctrl_we_i,
    input logic [1:0]           match_i,
    input logic [1:0]           pwm_i,
    input logic [1:0]           run_i,
    input logic [1:0]           free_i,
    input logic                 sync_i,
    input logic [1:0]           stage_a_i,
    input logic [1:0][CNT_W-1:0] cnt_i,
    input logic [1:0][CNT_W-1:0] a_i,
    input logic [1:0][CNT_W-1:0] b_i,
    input logic [1:0][CNT_W-1:0] c_i
);
    for (genvar i = 0; i < 2; i++) begin : g_chk
        // R4
        wrap_to_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            match_i[i] |=> (cnt_i[i] == '0));

        // R2
        self_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (match_i[i] && !free_i[i] && !ctrl_we_i) |=> !run_i[i]);

        // R3
        free_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (match_i[i] && free_i[i] && !ctrl_we_i) |=> run_i[i]);

        // R5
        duty_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($fell(pwm_i[i]) && run_i[i] && $past(run_i[i]) && $stable(b_i[i]))
                |-> (cnt_i[i] == b_i[i]));

        // R7
        stage_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (match_i[i] && stage_a_i[i]) |=> (a_i[i] == $past(c_i[i])));

        // R6
        sync_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (sync_i && match_i[i]) |=> (cnt_i[1-i] == '0));
    end
endmodule

bind dual_pwm_timer dual_pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_we_i (ctrl_we),
    .match_i   (match_o),
    .pwm_i     (pwm_o),
    .run_i     (run_w),
    .free_i    (free_w),
    .sync_i    (sync_w),
    .stage_a_i (stage_a_w),
    .cnt_i     (cnt_w),
    .a_i       (a_w),
    .b_i       (b_w),
    .c_i       (c_w)
);

// File: tb/dual_pwm_timer_bench.sv
module dual_pwm_timer_bench;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 4;
    localparam int NVEC   = 6;

    // {period A, duty B, expected high cycles per period}
    localparam logic [47:0] VEC [NVEC] = '{
        {16'd9,  16'd4,  16'd4},
        {16'd9,  16'd0,  16'd0},
        {16'd9,  16'd12, 16'd10},
        {16'd3,  16'd3,  16'd3},
        {16'd0,  16'd1,  16'd1},
        {16'd15, 16'd8,  16'd8}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [CNT_W-1:0]  wdata = '0;
    logic [CNT_W-1:0]  rdata;
    logic [1:0]        pwm, match;
    int                checks = 0;
    int                errors = 0;

    always #2 clk = ~clk;

    dual_pwm_timer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dual_pwm_timer (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .pwm_o       (pwm),
        .match_o     (match)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        we = 1'b1; addr = ADDR_W'(a); wdata = CNT_W'(d);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        addr = ADDR_W'(a);
        #1;
        d = int'(rdata);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic count_match(input int cycles, output int m0, output int m1);
        m0 = 0; m1 = 0;
        for (int k = 0; k < cycles; k++) begin
            m0 += int'(match[0]);
            m1 += int'(match[1]);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v, m0, m1, hi;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        rd(0, v); check("R10 ctrl", v, 0);
        rd(1, v); check("R10 mode", v, 32'hE0);
        check("R10 pwm", int'(pwm), 0);
        check("R10 match", int'(match), 0);

        // R5 / R2 vector table: self-stopping single period per entry
        for (int i = 0; i < NVEC; i++) begin
            wr(2, int'(VEC[i][47:32]));
            wr(3, int'(VEC[i][31:16]));
            wr(0, 32'h01);
            hi = 0;
            for (int k = 0; k <= int'(VEC[i][47:32]); k++) begin
                hi += int'(pwm[0]);
                @(negedge clk);
            end
            check("R5 high cycles", hi, int'(VEC[i][15:0]));
            rd(0, v); check("R2 self stop", v & 1, 0);
        end

        // R1 start, then stop drives PWM low
        do_reset();
        wr(2, 100); wr(3, 50); wr(0, 32'h05);
        repeat (3) @(negedge clk);
        check("R1 running pwm", int'(pwm[0]), 1);
        wr(0, 32'h00);
        check("R1 stopped pwm", int'(pwm[0]), 0);

        // R3 / R4 free running, period A+1
        do_reset();
        wr(2, 4); wr(0, 32'h05);
        count_match(20, m0, m1);
        check("R4 matches in 20 cycles", m0, 4);
        rd(0, v); check("R3 still running", v & 1, 1);

        // R6 sync on: channel 1 never reaches its longer period
        do_reset();
        wr(2, 3); wr(6, 9); wr(1, 32'h01); wr(0, 32'h0F);
        count_match(30, m0, m1);
        check("R6 sync ch0 matches", m0, 7);
        check("R6 sync ch1 matches", m1, 0);

        // R6 sync off: independent
        do_reset();
        wr(2, 3); wr(6, 9); wr(0, 32'h0F);
        count_match(30, m0, m1);
        check("R6 indep ch1 matches", m1, 3);

        // R7 staged transfer only at period match
        do_reset();
        wr(2, 4); wr(3, 2); wr(4, 7); wr(5, 5); wr(1, 32'h06); wr(0, 32'h05);
        rd(2, v); check("R7 A before match", v, 4);
        repeat (5) @(negedge clk);
        rd(2, v); check("R7 A after match", v, 7);
        rd(3, v); check("R7 B after match", v, 5);
        wr(4, 9);
        rd(2, v); check("R7 A mid period", v, 7);
        repeat (7) @(negedge clk);
        rd(2, v); check("R7 A next boundary", v, 9);

        // R7 general-purpose C is never copied
        do_reset();
        wr(2, 4); wr(4, 7); wr(0, 32'h05);
        repeat (6) @(negedge clk);
        rd(2, v); check("R7 general C not copied", v, 4);

        // R8 unassigned mode bits
        wr(1, 32'h00); rd(1, v); check("R8 mode write 0", v, 32'hE0);
        wr(1, 32'hFF); rd(1, v); check("R8 mode write FF", v, 32'hFF);

        // R9 write of 1 in the hardware-clear cycle keeps running
        do_reset();
        wr(2, 3); wr(0, 32'h01);
        repeat (3) @(negedge clk);
        check("R4 match strobe at A", int'(match[0]), 1);
        wr(0, 32'h01);
        rd(0, v); check("R9 written 1 wins", v, 32'h01);
        repeat (3) @(negedge clk);
        check("R9 still counting", int'(match[0]), 1);

        // R9 write of 0 in the hardware-clear cycle stops
        do_reset();
        wr(2, 3); wr(0, 32'h01);
        repeat (3) @(negedge clk);
        wr(0, 32'h02);
        rd(0, v); check("R9 written 0 stops ch0", v, 32'h02);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule